// File: doc/BRIEF.md
# Address-Space-Tagged Translation Cache

This block is a small, fully associative cache of virtual-to-physical page translations. A lookup takes a 32-bit virtual address and the identifier of the running address space. It compares the upper 20 bits of the address, which form the page number, and the identifier against every stored entry. On a hit it returns the cached frame number with the low 12 offset bits attached unchanged. On a miss it reports a miss. An outside walker or trap handler then installs the translation through a privileged fill port, and the access is retried.

Every entry carries an address-space identifier, so translations that belong to different processes can be held at the same time. Software can drop every cached translation with a flush. Loading a new value into the page-table base register held inside the block has the same effect. Results are registered and appear one cycle after the request.

Top module: `asid_tlb`

## Requirements
- R1: After reset no entry is valid, `rsp_valid_o` is low and every lookup misses.
- R2: `rsp_valid_o` is high in exactly the cycle after a cycle with `lookup_req_i` high.
- R3: A lookup hits when a valid entry has page number `lookup_vaddr_i[31:12]` and identifier `cur_asid_i`. `rsp_paddr_o` is then `{pfn, lookup_vaddr_i[11:0]}`.
- R4: On a miss `rsp_hit_o` is 0 and `rsp_paddr_o` is 0.
- R5: An entry matches only its own identifier. The same page number under two identifiers is held as two separate entries.
- R6: A fill that matches no valid entry writes the lowest-indexed invalid entry. If every entry is valid, it writes the entry named by a victim pointer. The pointer starts at 0, steps by one (wrapping) after each such replacement, and returns to 0 on any flush.
- R7: A fill whose page number and identifier match a valid entry overwrites that entry's frame number. It creates no duplicate and does not move the victim pointer.
- R8: A cycle with `flush_i` high makes every entry invalid from the next cycle on.
- R9: A write on `ptbr_we_i` whose data differs from the stored base value invalidates every entry. A write of the same value leaves the entries intact. Reset sets the stored base value to 0.
- R10: A fill in the same cycle as a flush from either source is dropped.
- R11: A lookup in the same cycle as a fill or a flush sees the contents from before that update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lookup_req_i | input | 1 | Lookup request |
| lookup_vaddr_i | input | 32 | Virtual address to translate |
| cur_asid_i | input | 8 | Identifier of the running address space |
| fill_en_i | input | 1 | Install a translation |
| fill_vpn_i | input | 20 | Page number to install |
| fill_asid_i | input | 8 | Identifier to install |
| fill_pfn_i | input | 20 | Frame number to install |
| flush_i | input | 1 | Invalidate every entry |
| ptbr_we_i | input | 1 | Page-table base register write |
| ptbr_data_i | input | 32 | New page-table base value |
| rsp_valid_o | output | 1 | Lookup result valid |
| rsp_hit_o | output | 1 | Lookup hit |
| rsp_paddr_o | output | 32 | Translated physical address, 0 on a miss |

## Verification
The assertions take for granted that inputs are held stable across each rising edge and that reset is applied before any request. The duplicate-free check relies on all installs going through the fill port, which folds a repeated page number and identifier back into the existing entry. The stimulus drives every input on the falling edge. It stacks fills, flushes, base-register writes and lookups in the same cycle only in the combinations the requirements define. Every fill stays a plain page number, identifier and frame triple.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  localparam int unsigned VA_W_D    = 32;
  localparam int unsigned OFS_W_D   = 12;
  localparam int unsigned PFN_W_D   = 20;
  localparam int unsigned ASID_W_D  = 8;
  localparam int unsigned ENTRIES_D = 8;
endpackage

// File: rtl/tlb_cam_row.sv
module tlb_cam_row #(
  parameter int unsigned N      = 8,
  parameter int unsigned VPN_W  = 20,
  parameter int unsigned ASID_W = 8
) (
  input  logic [N-1:0]             valid,
  input  logic [N-1:0][VPN_W-1:0]  tag_vpn,
  input  logic [N-1:0][ASID_W-1:0] tag_asid,
  input  logic [VPN_W-1:0]         q_vpn,
  input  logic [ASID_W-1:0]        q_asid,
  output logic [N-1:0]             match
);
  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign match[g] = valid[g] && (tag_vpn[g] == q_vpn) && (tag_asid[g] == q_asid);
  end
endmodule

// File: rtl/tlb_victim_sel.sv
module tlb_victim_sel #(
  parameter int unsigned N     = 8,
  parameter int unsigned IDX_W = 3
) (
  input  logic [N-1:0]     valid,
  input  logic [N-1:0]     same,
  input  logic [IDX_W-1:0] ptr,
  output logic [IDX_W-1:0] idx,
  output logic             use_ptr
);
  always_comb begin
    idx     = ptr;
    use_ptr = 1'b1;
    if (|same) begin
      use_ptr = 1'b0;
      for (int i = 0; i < N; i++) if (same[i]) idx = IDX_W'(i);
    end else if (~&valid) begin
      use_ptr = 1'b0;
      for (int i = N - 1; i >= 0; i--) if (!valid[i]) idx = IDX_W'(i);
    end
  end
endmodule

// File: rtl/asid_tlb.sv
module asid_tlb
  import tlb_pkg::*;
#(
  parameter int unsigned VA_W    = VA_W_D,
  parameter int unsigned OFS_W   = OFS_W_D,
  parameter int unsigned PFN_W   = PFN_W_D,
  parameter int unsigned ASID_W  = ASID_W_D,
  parameter int unsigned ENTRIES = ENTRIES_D,
  localparam int unsigned VPN_W  = VA_W - OFS_W,
  localparam int unsigned PA_W   = PFN_W + OFS_W,
  localparam int unsigned IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              lookup_req_i,
  input  logic [VA_W-1:0]   lookup_vaddr_i,
  input  logic [ASID_W-1:0] cur_asid_i,
  input  logic              fill_en_i,
  input  logic [VPN_W-1:0]  fill_vpn_i,
  input  logic [ASID_W-1:0] fill_asid_i,
  input  logic [PFN_W-1:0]  fill_pfn_i,
  input  logic              flush_i,
  input  logic              ptbr_we_i,
  input  logic [VA_W-1:0]   ptbr_data_i,
  output logic              rsp_valid_o,
  output logic              rsp_hit_o,
  output logic [PA_W-1:0]   rsp_paddr_o
);
  logic [ENTRIES-1:0]             valid_q;
  logic [ENTRIES-1:0][VPN_W-1:0]  vpn_q;
  logic [ENTRIES-1:0][ASID_W-1:0] asid_q;
  logic [ENTRIES-1:0][PFN_W-1:0]  pfn_q;
  logic [IDX_W-1:0]               ptr_q;
  logic [VA_W-1:0]                ptbr_q;

  logic [ENTRIES-1:0] lk_match, fl_match;
  logic [IDX_W-1:0]   fill_idx;
  logic               fill_use_ptr;
  logic               flush_all, fill_go;
  logic [PFN_W-1:0]   lk_pfn;

  tlb_cam_row #(.N(ENTRIES), .VPN_W(VPN_W), .ASID_W(ASID_W)) u_lk_cam (
    .valid(valid_q), .tag_vpn(vpn_q), .tag_asid(asid_q),
    .q_vpn(lookup_vaddr_i[VA_W-1:OFS_W]), .q_asid(cur_asid_i), .match(lk_match)
  );

  tlb_cam_row #(.N(ENTRIES), .VPN_W(VPN_W), .ASID_W(ASID_W)) u_fl_cam (
    .valid(valid_q), .tag_vpn(vpn_q), .tag_asid(asid_q),
    .q_vpn(fill_vpn_i), .q_asid(fill_asid_i), .match(fl_match)
  );

  tlb_victim_sel #(.N(ENTRIES), .IDX_W(IDX_W)) u_victim (
    .valid(valid_q), .same(fl_match), .ptr(ptr_q),
    .idx(fill_idx), .use_ptr(fill_use_ptr)
  );

  assign flush_all = flush_i || (ptbr_we_i && (ptbr_data_i != ptbr_q));
  assign fill_go   = fill_en_i && !flush_all;

  always_comb begin
    lk_pfn = '0;
    for (int i = 0; i < ENTRIES; i++) if (lk_match[i]) lk_pfn |= pfn_q[i];
  end

  // control state
  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= '0;
      ptr_q   <= '0;
      ptbr_q  <= '0;
    end else begin
      if (ptbr_we_i) ptbr_q <= ptbr_data_i;
      if (flush_all) begin
        valid_q <= '0;
        ptr_q   <= '0;
      end else if (fill_go) begin
        valid_q[fill_idx] <= 1'b1;
        if (fill_use_ptr)
          ptr_q <= (ptr_q == IDX_W'(ENTRIES - 1)) ? '0 : ptr_q + 1'b1;
      end
    end
  end

  // tag and frame storage, no reset
  always_ff @(posedge clk) begin
    if (fill_go) begin
      vpn_q[fill_idx]  <= fill_vpn_i;
      asid_q[fill_idx] <= fill_asid_i;
      pfn_q[fill_idx]  <= fill_pfn_i;
    end
  end

  // registered response
  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid_o <= 1'b0;
      rsp_hit_o   <= 1'b0;
      rsp_paddr_o <= '0;
    end else begin
      rsp_valid_o <= lookup_req_i;
      rsp_hit_o   <= lookup_req_i && (|lk_match);
      rsp_paddr_o <= (lookup_req_i && (|lk_match)) ? {lk_pfn, lookup_vaddr_i[OFS_W-1:0]} : '0;
    end
  end

  // R7
  no_dup_entry_chk: assert property (@(posedge clk) disable iff (rst) $onehot0(lk_match));
  // R8
  flush_clears_chk: assert property (@(posedge clk) disable iff (rst) flush_all |=> (valid_q == '0));
  // R2
  rsp_timing_chk: assert property (@(posedge clk) disable iff (rst) lookup_req_i |=> rsp_valid_o);
  // R2
  rsp_idle_chk: assert property (@(posedge clk) disable iff (rst) !lookup_req_i |=> !rsp_valid_o);
  // R3
  offset_pass_chk: assert property (@(posedge clk) disable iff (rst)
    lookup_req_i |=> (!rsp_hit_o || rsp_paddr_o[OFS_W-1:0] == $past(lookup_vaddr_i[OFS_W-1:0])));
  // R4
  miss_zero_chk: assert property (@(posedge clk) disable iff (rst) !rsp_hit_o |-> (rsp_paddr_o == '0));
  // R6
  fill_lands_chk: assert property (@(posedge clk) disable iff (rst) fill_go |=> (valid_q != '0));
endmodule

// File: tb/asid_tlb_tb.sv
module asid_tlb_tb;
  localparam int N = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        lookup_req_i = 1'b0;
  logic [31:0] lookup_vaddr_i = '0;
  logic [7:0]  cur_asid_i = '0;
  logic        fill_en_i = 1'b0;
  logic [19:0] fill_vpn_i = '0;
  logic [7:0]  fill_asid_i = '0;
  logic [19:0] fill_pfn_i = '0;
  logic        flush_i = 1'b0;
  logic        ptbr_we_i = 1'b0;
  logic [31:0] ptbr_data_i = '0;
  logic        rsp_valid_o, rsp_hit_o;
  logic [31:0] rsp_paddr_o;

  int checks = 0;
  int errors = 0;
  string tag = "R1";

  asid_tlb u_dut (.*);

  always #4 clk = ~clk;

  // behavioural reference
  bit          m_v[N];
  int          m_vpn[N], m_asid[N], m_pfn[N];
  int          m_ptr;
  int          m_ptbr;
  bit          e_valid, e_hit;
  logic [31:0] e_pa;

  always @(posedge clk) begin
    if (rst) begin
      foreach (m_v[i]) m_v[i] = 0;
      m_ptr = 0; m_ptbr = 0;
      e_valid = 0; e_hit = 0; e_pa = 0;
    end else begin
      bit fl;
      int slot;
      e_valid = lookup_req_i; e_hit = 0; e_pa = 0;
      if (lookup_req_i)
        foreach (m_v[i])
          if (m_v[i] && m_vpn[i] == int'(lookup_vaddr_i[31:12]) && m_asid[i] == int'(cur_asid_i)) begin
            e_hit = 1; e_pa = {m_pfn[i][19:0], lookup_vaddr_i[11:0]};
          end
      fl = flush_i || (ptbr_we_i && int'(ptbr_data_i) != m_ptbr);
      if (ptbr_we_i) m_ptbr = int'(ptbr_data_i);
      if (fl) begin
        foreach (m_v[i]) m_v[i] = 0;
        m_ptr = 0;
      end else if (fill_en_i) begin
        slot = -1;
        foreach (m_v[i]) if (slot < 0 && m_v[i] && m_vpn[i] == int'(fill_vpn_i) && m_asid[i] == int'(fill_asid_i)) slot = i;
        if (slot < 0) foreach (m_v[i]) if (slot < 0 && !m_v[i]) slot = i;
        if (slot < 0) begin slot = m_ptr; m_ptr = (m_ptr + 1) % N; end
        m_v[slot] = 1; m_vpn[slot] = int'(fill_vpn_i);
        m_asid[slot] = int'(fill_asid_i); m_pfn[slot] = int'(fill_pfn_i);
      end
    end
  end

  always @(negedge clk) if (!rst) begin
    checks++;
    if (rsp_valid_o !== e_valid || rsp_hit_o !== e_hit || rsp_paddr_o !== e_pa) begin
      errors++;
      $display("FAIL %s model: got v%0b h%0b %h expected v%0b h%0b %h",
               tag, rsp_valid_o, rsp_hit_o, rsp_paddr_o, e_valid, e_hit, e_pa);
    end
  end

  task automatic chk(input string r, input bit hit, input logic [31:0] pa, input logic [31:0] xpa, input bit xhit);
    checks++;
    if (hit !== xhit || pa !== xpa) begin
      errors++;
      $display("FAIL %s: got hit %0b pa %h expected hit %0b pa %h", r, hit, pa, xhit, xpa);
    end
  endtask

  task automatic look(input string r, input logic [31:0] va, input logic [7:0] asid, input bit xhit, input logic [31:0] xpa);
    tag = r;
    lookup_req_i = 1; lookup_vaddr_i = va; cur_asid_i = asid;
    @(negedge clk);
    lookup_req_i = 0;
    chk(r, rsp_hit_o, rsp_paddr_o, xpa, xhit);
  endtask

  task automatic fill(input logic [19:0] vpn, input logic [7:0] asid, input logic [19:0] pfn);
    fill_en_i = 1; fill_vpn_i = vpn; fill_asid_i = asid; fill_pfn_i = pfn;
    @(negedge clk);
    fill_en_i = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    // R1
    checks++;
    if (rsp_valid_o !== 1'b0) begin errors++; $display("FAIL R1: rsp_valid %0b expected 0", rsp_valid_o); end
    look("R1", 32'h12345678, 8'd1, 0, 32'h0);

    // R3 R4 R5
    fill(20'h12345, 8'd1, 20'hABCDE);
    look("R3", 32'h12345678, 8'd1, 1, 32'hABCDE678);
    look("R5", 32'h12345678, 8'd2, 0, 32'h0);
    look("R4", 32'h54321000, 8'd1, 0, 32'h0);
    fill(20'h12345, 8'd2, 20'h11111);
    look("R5", 32'h12345FFF, 8'd2, 1, 32'h11111FFF);
    look("R5", 32'h12345000, 8'd1, 1, 32'hABCDE000);

    // R11 lookup during the fill that installs it
    tag = "R11";
    fill_en_i = 1; fill_vpn_i = 20'h00777; fill_asid_i = 8'd1; fill_pfn_i = 20'h00888;
    lookup_req_i = 1; lookup_vaddr_i = 32'h00777ABC; cur_asid_i = 8'd1;
    @(negedge clk);
    fill_en_i = 0; lookup_req_i = 0;
    chk("R11", rsp_hit_o, rsp_paddr_o, 32'h0, 0);
    look("R11", 32'h00777ABC, 8'd1, 1, 32'h00888ABC);

    // R8 R11 flush with concurrent lookup
    tag = "R8";
    flush_i = 1; lookup_req_i = 1; lookup_vaddr_i = 32'h12345678; cur_asid_i = 8'd1;
    @(negedge clk);
    flush_i = 0; lookup_req_i = 0;
    chk("R11", rsp_hit_o, rsp_paddr_o, 32'hABCDE678, 1);
    look("R8", 32'h12345678, 8'd1, 0, 32'h0);
    look("R8", 32'h00777ABC, 8'd1, 0, 32'h0);

    // R6 R7
    tag = "R6";
    for (int i = 0; i < N; i++) fill(20'h00100 + 20'(i), 8'd3, 20'h00200 + 20'(i));
    for (int i = 0; i < N; i++) look("R6", {20'h00100 + 20'(i), 12'h010}, 8'd3, 1, {20'h00200 + 20'(i), 12'h010});
    fill(20'h00103, 8'd3, 20'h003FF);
    look("R7", 32'h00103020, 8'd3, 1, 32'h003FF020);
    look("R7", 32'h00100020, 8'd3, 1, 32'h00200020);
    fill(20'h00900, 8'd3, 20'h00901);
    look("R6", 32'h00100000, 8'd3, 0, 32'h0);
    look("R6", 32'h00900004, 8'd3, 1, 32'h00901004);
    look("R6", 32'h00101004, 8'd3, 1, 32'h00201004);
    fill(20'h00902, 8'd3, 20'h00903);
    look("R6", 32'h00101004, 8'd3, 0, 32'h0);
    look("R7", 32'h00103004, 8'd3, 1, 32'h003FF004);

    // R10
    tag = "R10";
    flush_i = 1; fill_en_i = 1; fill_vpn_i = 20'h00AAA; fill_asid_i = 8'd4; fill_pfn_i = 20'h00BBB;
    @(negedge clk);
    flush_i = 0; fill_en_i = 0;
    look("R10", 32'h00AAA000, 8'd4, 0, 32'h0);
    look("R10", 32'h00103000, 8'd3, 0, 32'h0);

    // R9
    fill(20'h00C00, 8'd5, 20'h00D00);
    tag = "R9";
    ptbr_we_i = 1; ptbr_data_i = 32'h0;
    @(negedge clk);
    ptbr_we_i = 0;
    look("R9", 32'h00C00123, 8'd5, 1, 32'h00D00123);
    ptbr_we_i = 1; ptbr_data_i = 32'h00001000;
    @(negedge clk);
    ptbr_we_i = 0;
    look("R9", 32'h00C00123, 8'd5, 0, 32'h0);
    fill(20'h00C00, 8'd5, 20'h00D01);
    ptbr_we_i = 1; ptbr_data_i = 32'h00001000;
    @(negedge clk);
    ptbr_we_i = 0;
    look("R9", 32'h00C00123, 8'd5, 1, 32'h00D01123);
    // R10 fill alongside a changing base write
    ptbr_we_i = 1; ptbr_data_i = 32'h00002000;
    fill_en_i = 1; fill_vpn_i = 20'h00E00; fill_asid_i = 8'd5; fill_pfn_i = 20'h00E01;
    @(negedge clk);
    ptbr_we_i = 0; fill_en_i = 0;
    look("R10", 32'h00E00000, 8'd5, 0, 32'h0);

    repeat (2) @(negedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule